// File: doc/BRIEF.md
# UART Bit-Rate Enable Generator

This block derives the bit-timing enables for a serial transmitter and receiver from one reference clock. The clock cycles first pass through an optional divide-by-8 stage. The result, called the selected clock, feeds a programmable sample divider that emits a one-cycle sample tick. Each path then has its own programmable period counter. That counter counts sample ticks and emits a one-cycle bit strobe once per bit period.

The divider values and the prescale select come from configuration inputs. The bit rate is the selected clock rate divided by (sample divisor × (period value + 1)). Software must change the rates only while both paths are disabled. It then pulses both path resets and enables the paths again. The shift registers and the register interface are not part of this block.

Top module: `uart_baud_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `sample_tick`, `tx_bit_stb` and `rx_bit_stb` are low.
- R2: With `presc_sel` low and `cd_val` = N ≥ 2, `sample_tick` is high for one clock cycle out of every N.
- R3: With `presc_sel` high, only every 8th reference cycle is a selected-clock edge, so `sample_tick` repeats every 8×N cycles.
- R4: With `cd_val` = 1, every selected-clock edge produces a sample tick. With the prescaler off, `sample_tick` stays high continuously.
- R5: With `cd_val` = 0, `sample_tick` never rises.
- R6: An enabled path raises its bit strobe for one cycle, one cycle after every (P+1)-th sample tick, where P is the effective period value.
- R7: The effective period value is `bdiv_val` when `bdiv_val` ≥ 4. Values 0 to 3 act as 4.
- R8: While a path's enable is low, its bit strobe stays low. `sample_tick` continues as long as `cd_val` is nonzero.
- R9: A path reset clears that path's period count and takes priority over its enable. After the reset is released, the first strobe follows exactly P+1 sample ticks.
- R10: The transmit and receive period counters run independently. Disabling or resetting one path leaves the other path's strobe timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| presc_sel | input | 1 | 1 = divide the reference clock by 8 before the sample divider |
| cd_val | input | CD_W | Sample divisor (0 stops the generator) |
| bdiv_val | input | BDIV_W | Bit period value; the period is value+1 sample ticks, with a minimum value of 4 |
| tx_en | input | 1 | Transmit path enable |
| rx_en | input | 1 | Receive path enable |
| tx_rst | input | 1 | Transmit path period counter reset |
| rx_rst | input | 1 | Receive path period counter reset |
| sample_tick | output | 1 | One-cycle sample enable |
| tx_bit_stb | output | 1 | One-cycle transmit bit strobe |
| rx_bit_stb | output | 1 | One-cycle receive bit strobe |

## Verification
The sample divider is tried at several settings. A divisor of 3 with the prescaler off separates divide-by-N from off-by-one periods. The same divisor with the prescaler on shows whether the ×8 stage is applied. Divisors of 1 and 0 cover the always-on and stopped extremes. Period values of 5 and 2 show the normal period and the clamp to 4. A run with one path disabled, and a reset pulse on the other path while it is enabled, show that the paths are independent and that reset sets the period phase. Every cycle is compared against a behavioural model.

// File: rtl/ubg_pkg.sv
package ubg_pkg;
  localparam int NPATH   = 2;
  localparam int PATH_TX = 0;
  localparam int PATH_RX = 1;
  localparam int MIN_PERIOD = 4;
endpackage

// File: rtl/ubg_prescaler.sv
module ubg_prescaler #(
  parameter int RATIO = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic presc_sel,
  output logic sel_tick
);
  localparam int PW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

  logic [PW-1:0] pre_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt <= '0;
    end else if (pre_cnt == LAST) begin
      pre_cnt <= '0;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  assign sel_tick = presc_sel ? (pre_cnt == LAST) : 1'b1;

  // R3: with the prescaler on, selected edges never come back to back
  p_presc_spacing_r3: assert property (@(posedge clk) disable iff (rst)
    (presc_sel && sel_tick) |=> !(presc_sel && sel_tick))
    else $error("prescaler emitted back-to-back selected edges");
endmodule

// File: rtl/ubg_cd_div.sv
module ubg_cd_div #(
  parameter int CD_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sel_tick,
  input  logic [CD_W-1:0] cd_val,
  output logic            sample_tick
);
  logic [CD_W-1:0] cd_cnt;
  logic [CD_W-1:0] cd_last;

  assign cd_last = cd_val - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cd_cnt      <= '0;
      sample_tick <= 1'b0;
    end else if (sel_tick && (cd_val != '0)) begin
      if (cd_cnt >= cd_last) begin
        cd_cnt      <= '0;
        sample_tick <= 1'b1;
      end else begin
        cd_cnt      <= cd_cnt + 1'b1;
        sample_tick <= 1'b0;
      end
    end else begin
      sample_tick <= 1'b0;
    end
  end

  // R5: a zero divisor stops the sample tick
  p_cd_zero_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (cd_val == '0) |=> !sample_tick)
    else $error("sample tick with zero divisor");

  // R2: with a divisor of two or more, a tick is never followed by another
  p_tick_single_r2: assert property (@(posedge clk) disable iff (rst)
    (sample_tick && (cd_val > 1)) |=> !sample_tick)
    else $error("sample tick lasted more than one cycle");
endmodule

// File: rtl/ubg_bit_div.sv
module ubg_bit_div #(
  parameter int BDIV_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              path_rst,
  input  logic              path_en,
  input  logic              sample_tick,
  input  logic [BDIV_W-1:0] bdiv_val,
  output logic              bit_stb
);
  import ubg_pkg::*;

  localparam logic [BDIV_W-1:0] FLOOR = BDIV_W'(MIN_PERIOD);

  logic [BDIV_W-1:0] bcnt;
  logic [BDIV_W-1:0] limit;

  assign limit = (bdiv_val < FLOOR) ? FLOOR : bdiv_val;

  always_ff @(posedge clk) begin
    if (rst || path_rst || !path_en) begin
      bcnt    <= '0;
      bit_stb <= 1'b0;
    end else if (sample_tick) begin
      if (bcnt >= limit) begin
        bcnt    <= '0;
        bit_stb <= 1'b1;
      end else begin
        bcnt    <= bcnt + 1'b1;
        bit_stb <= 1'b0;
      end
    end else begin
      bit_stb <= 1'b0;
    end
  end

  // R8: a disabled path stays quiet
  p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !path_en |=> !bit_stb)
    else $error("strobe on a disabled path");

  // R9: a path reset returns the count to zero
  p_reset_clears_r9: assert property (@(posedge clk) disable iff (rst)
    path_rst |=> (bcnt == '0 && !bit_stb))
    else $error("path reset did not clear the period count");

  // R6: every strobe follows a sample tick
  p_stb_after_tick_r6: assert property (@(posedge clk) disable iff (rst)
    bit_stb |-> $past(sample_tick))
    else $error("bit strobe without a preceding sample tick");
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int CD_W   = 16,
  parameter int BDIV_W = 8,
  parameter int PRESC  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              presc_sel,
  input  logic [CD_W-1:0]   cd_val,
  input  logic [BDIV_W-1:0] bdiv_val,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              tx_rst,
  input  logic              rx_rst,
  output logic              sample_tick,
  output logic              tx_bit_stb,
  output logic              rx_bit_stb
);
  import ubg_pkg::*;

  logic             sel_tick;
  logic [NPATH-1:0] en_v;
  logic [NPATH-1:0] rst_v;
  logic [NPATH-1:0] stb_v;

  assign en_v[PATH_TX]  = tx_en;
  assign en_v[PATH_RX]  = rx_en;
  assign rst_v[PATH_TX] = tx_rst;
  assign rst_v[PATH_RX] = rx_rst;

  ubg_prescaler #(.RATIO(PRESC)) u_presc (
    .clk       (clk),
    .rst       (rst),
    .presc_sel (presc_sel),
    .sel_tick  (sel_tick)
  );

  ubg_cd_div #(.CD_W(CD_W)) u_cd (
    .clk         (clk),
    .rst         (rst),
    .sel_tick    (sel_tick),
    .cd_val      (cd_val),
    .sample_tick (sample_tick)
  );

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    ubg_bit_div #(.BDIV_W(BDIV_W)) u_bit (
      .clk         (clk),
      .rst         (rst),
      .path_rst    (rst_v[p]),
      .path_en     (en_v[p]),
      .sample_tick (sample_tick),
      .bdiv_val    (bdiv_val),
      .bit_stb     (stb_v[p])
    );
  end

  assign tx_bit_stb = stb_v[PATH_TX];
  assign rx_bit_stb = stb_v[PATH_RX];

  // R1: outputs are quiet in the cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> !(sample_tick || tx_bit_stb || rx_bit_stb))
    else $error("output active right after reset");
endmodule

// File: tb/uart_baud_gen_tb.sv
`timescale 1ns/1ps
module uart_baud_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        presc_sel = 1'b0;
  logic [15:0] cd_val = 16'd3;
  logic [7:0]  bdiv_val = 8'd5;
  logic        tx_en = 1'b0, rx_en = 1'b0, tx_rst = 1'b0, rx_rst = 1'b0;
  logic        sample_tick, tx_bit_stb, rx_bit_stb;

  int checks = 0;
  int bad = 0;
  string cur_req = "R1";
  bit started = 1'b0;

  always #10 clk = ~clk;

  uart_baud_gen u_dut (
    .clk(clk), .rst(rst), .presc_sel(presc_sel), .cd_val(cd_val),
    .bdiv_val(bdiv_val), .tx_en(tx_en), .rx_en(rx_en), .tx_rst(tx_rst),
    .rx_rst(rx_rst), .sample_tick(sample_tick), .tx_bit_stb(tx_bit_stb),
    .rx_bit_stb(rx_bit_stb)
  );

  // behavioural reference: counts of reference cycles and sample ticks
  int  m_pre = 0, m_cd = 0;
  int  m_bc[2] = '{0, 0};
  bit  m_tick = 0;
  bit  m_stb[2] = '{0, 0};

  always @(posedge clk) begin
    bit sel;
    int per;
    bit en[2];
    bit pr[2];
    en[0] = tx_en; en[1] = rx_en; pr[0] = tx_rst; pr[1] = rx_rst;
    if (rst) begin
      m_pre = 0; m_cd = 0; m_tick = 0;
      for (int p = 0; p < 2; p++) begin m_bc[p] = 0; m_stb[p] = 0; end
    end else begin
      per = (bdiv_val < 4) ? 4 : int'(bdiv_val);
      for (int p = 0; p < 2; p++) begin
        if (pr[p] || !en[p]) begin m_bc[p] = 0; m_stb[p] = 0; end
        else if (m_tick) begin
          if (m_bc[p] >= per) begin m_bc[p] = 0; m_stb[p] = 1; end
          else begin m_bc[p]++; m_stb[p] = 0; end
        end else m_stb[p] = 0;
      end
      sel = presc_sel ? (m_pre == 7) : 1'b1;
      m_pre = (m_pre + 1) % 8;
      if (sel && cd_val != 0) begin
        if (m_cd + 1 >= int'(cd_val)) begin m_cd = 0; m_tick = 1; end
        else begin m_cd++; m_tick = 0; end
      end else m_tick = 0;
    end
  end

  int n_tick = 0, n_tx = 0, n_rx = 0;

  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (sample_tick !== m_tick || tx_bit_stb !== m_stb[0] || rx_bit_stb !== m_stb[1]) begin
        bad++;
        $display("FAIL %s: tick/tx/rx actual=%b%b%b expected=%b%b%b at %0t",
                 cur_req, sample_tick, tx_bit_stb, rx_bit_stb,
                 m_tick, m_stb[0], m_stb[1], $time);
      end
      n_tick += int'(sample_tick);
      n_tx   += int'(tx_bit_stb);
      n_rx   += int'(rx_bit_stb);
    end
  end

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_counts();
    @(negedge clk);
    n_tick = 0; n_tx = 0; n_rx = 0;
  endtask

  // rate change: disable, load, pulse resets, enable
  task automatic set_rate(input bit ps, input int cd, input int bd);
    @(negedge clk);
    tx_en = 0; rx_en = 0;
    @(negedge clk);
    presc_sel = ps; cd_val = 16'(cd); bdiv_val = 8'(bd);
    tx_rst = 1; rx_rst = 1;
    @(negedge clk);
    tx_rst = 0; rx_rst = 0; tx_en = 1; rx_en = 1;
  endtask

  initial begin
    started = 1'b1;
    run(4);
    check_eq("R1 tick in reset", int'(sample_tick), 0);
    check_eq("R1 strobes in reset", int'(tx_bit_stb | rx_bit_stb), 0);
    @(negedge clk); rst = 0; tx_en = 1; rx_en = 1;
    @(negedge clk);
    check_eq("R1 after reset", int'(sample_tick | tx_bit_stb | rx_bit_stb), 0);

    cur_req = "R2/R6";
    set_rate(0, 3, 5); clear_counts(); run(180);
    check_eq("R2 ticks in 180 cycles cd=3", n_tick, 60);
    check_eq("R6 tx strobes cd=3 bdiv=5", n_tx, 10);

    cur_req = "R4";
    set_rate(0, 1, 5); clear_counts(); run(60);
    check_eq("R4 tick every cycle", n_tick, 60);
    check_eq("R4 rx strobes", n_rx, 10);

    cur_req = "R3";
    set_rate(1, 3, 4); clear_counts(); run(240);
    check_eq("R3 prescaled ticks", n_tick, 10);

    cur_req = "R5";
    set_rate(0, 0, 5); clear_counts(); run(50);
    check_eq("R5 no ticks", n_tick, 0);
    check_eq("R5 no strobes", n_tx + n_rx, 0);

    cur_req = "R7";
    set_rate(0, 2, 2); clear_counts(); run(100);
    check_eq("R7 clamped period tx", n_tx, 10);

    cur_req = "R8/R10";
    set_rate(0, 2, 4);
    @(negedge clk); tx_en = 0;
    clear_counts(); run(100);
    check_eq("R8 disabled tx quiet", n_tx, 0);
    check_eq("R8 tick continues", n_tick, 50);
    check_eq("R10 rx unaffected", n_rx, 10);

    cur_req = "R9";
    tx_en = 1;
    run(7);
    rx_rst = 1; run(3); rx_rst = 0;
    check_eq("R9 rx quiet under reset", int'(rx_bit_stb), 0);
    run(80);
    run(5);
    started = 1'b0;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #4000000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule